// File: doc/BRIEF.md
# PWM-Synchronized Dual ADC Trigger Sequencer

This block issues two ADC start-of-conversion pulses in every period of a center-aligned PWM carrier. A sync pulse at the carrier trough opens a window that lasts half the PWM period. Inside that window a gated sample counter runs against a compare target.

The first match issues the current-sample trigger almost at once. The target is then advanced by a programmable delay, and the second match issues the voltage-sample trigger while the low-side switch conducts. After that the counter is halted and cleared until the next sync. The window close re-arms the sequence.

Two sticky status flags report timing faults:
- A trigger issued while the converter reports busy would be ignored by the converter, so it is flagged as dropped, together with its sample index.
- A period that closes before its second trigger is flagged as missed.

The sequencer has four states:
- `SEQ_IDLE`: no window is open.
- `SEQ_FIRST`: waiting for the current-sample match.
- `SEQ_SECOND`: waiting for the voltage-sample match.
- `SEQ_DONE`: counter halted until the window closes.

Its transitions are:
- Any state goes to `SEQ_FIRST` on an accepted sync (window start).
- `SEQ_FIRST` goes to `SEQ_SECOND` on a match.
- `SEQ_SECOND` goes to `SEQ_DONE` on a match.
- `SEQ_FIRST`, `SEQ_SECOND` and `SEQ_DONE` go to `SEQ_IDLE` on window end. Window end takes priority over a match in the same cycle.

Top module: `adc_dual_trig_seq`

## Requirements
- R1: A sync pulse sampled with a nonzero half-period H raises `window_o` on the next cycle and keeps it high for exactly H cycles. A sync with H equal to zero is ignored.
- R2: Counting the sync edge as edge 0, the first trigger is a one-cycle `trig_o` pulse with `samp_idx_o`=0 after edge 2+t0. With t0=0 this is almost at once. `trig_o` is never high on the first cycle of a window.
- R3: The second trigger is a one-cycle `trig_o` pulse with `samp_idx_o`=1 after edge 2+t0+d, where d is t1 raised to a minimum of 2. The two pulses are therefore never on adjacent cycles.
- R4: At most two triggers are issued per window. After the second, the sample counter is halted and cleared, and no further trigger occurs until the next sync.
- R5: t0 and t1 are sampled at the window start. Changes to them during a window do not alter that window's trigger times.
- R6: The second trigger is issued only if t0+d is at most H-2. Otherwise it is suppressed and `miss_o` is set when the window closes.
- R7: `miss_o` is sticky and is cleared by `flag_clr_i[1]`; a set in the same cycle wins over the clear.
- R8: If `adc_busy_i` is high during a `trig_o` cycle, `drop_flag_o` rises on the next cycle and `drop_idx_o` takes that trigger's sample index. The trigger pulse itself is still issued.
- R9: `drop_flag_o` is sticky and is cleared by `flag_clr_i[0]`; a set in the same cycle wins over the clear.
- R10: After reset, `trig_o`, `samp_idx_o`, `window_o`, `drop_flag_o`, `drop_idx_o` and `miss_o` are all 0.
- R11: A sync that arrives while a window is open reloads the window to the new H and restarts the sequence from the first trigger. If that window's second trigger had not yet been issued, `miss_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_sync_i | input | 1 | One-cycle sync pulse at the carrier trough |
| half_period_i | input | CW | Window length H in clock cycles |
| delay_t0_i | input | CW | Extra delay before the first trigger |
| delay_t1_i | input | CW | Delay from first to second trigger (minimum 2 applied) |
| adc_busy_i | input | 1 | Converter scan in progress |
| flag_clr_i | input | 2 | Clear strobes: bit 0 clears the drop flag, bit 1 clears the miss flag |
| trig_o | output | 1 | Start-of-conversion pulse |
| samp_idx_o | output | 1 | Index of the latest trigger: 0 current, 1 voltage |
| window_o | output | 1 | Half-period window active |
| drop_flag_o | output | 1 | Sticky: a trigger was issued while the converter was busy |
| drop_idx_o | output | 1 | Sample index of the latest dropped trigger |
| miss_o | output | 1 | Sticky: a period closed without its second trigger |

## Verification
Periods are driven with zero and nonzero t0, with t1 below the minimum spacing, and with t0+t1 exactly at the window limit and one beyond it. These patterns separate the immediate first sample, the clamped spacing and the suppressed second sample. One period changes both delays mid-window to show they are latched at window start. Busy pulses are placed over only the first or only the second trigger, so a wrong dropped index is visible. A zero-length sync and a restarting sync mid-window exercise window reload and the miss flag on an unfinished period.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FIRST,
        SEQ_SECOND,
        SEQ_DONE
    } seq_state_e;

    // smallest spacing between first and second trigger, in clocks
    localparam int unsigned MIN_GAP = 2;

endpackage

// File: rtl/adc_trig_window.sv
module adc_trig_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic [CW-1:0] len_i,
    output logic          start_o,
    output logic          end_o,
    output logic          active_o
);
    localparam logic [CW-1:0] LAST = CW'(1);

    logic [CW-1:0] left_q;
    logic          act_q;

    assign start_o  = sync_i && (len_i != '0);
    assign end_o    = act_q && (left_q == LAST) && !start_o;
    assign active_o = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            act_q  <= 1'b0;
        end else if (start_o) begin
            left_q <= len_i;
            act_q  <= 1'b1;
        end else if (act_q) begin
            left_q <= left_q - LAST;
            if (left_q == LAST) begin
                act_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_trig_counter.sv
module adc_trig_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] t0_i,
    input  logic          run_i,
    input  logic          clear_i,
    input  logic          adv_i,
    input  logic [CW-1:0] adv_amt_i,
    output logic          hit_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tgt_q;

    assign hit_o = (cnt_q == tgt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= ONE;
        end else if (load_i) begin
            // first compare lands t0 clocks after the next count
            tgt_q <= cnt_q + ONE + t0_i;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else begin
            if (run_i) begin
                cnt_q <= cnt_q + ONE;
            end
            if (adv_i) begin
                tgt_q <= tgt_q + adv_amt_i;
            end
        end
    end
endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
    import adc_trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          end_i,
    input  logic          window_i,
    input  logic          hit_i,
    input  logic [CW-1:0] t1_i,
    output logic          run_o,
    output logic          clear_o,
    output logic          adv_o,
    output logic [CW-1:0] adv_amt_o,
    output logic          trig_o,
    output logic          idx_o,
    output logic          miss_set_o
);
    localparam logic [CW-1:0] GAP = CW'(MIN_GAP);

    seq_state_e    st_q, st_d;
    logic [CW-1:0] t1_q;
    logic          match;
    logic          armed;
    logic          trig_q, idx_q;

    assign armed = (st_q == SEQ_FIRST) || (st_q == SEQ_SECOND);
    assign match = window_i && !start_i && hit_i && armed;

    assign run_o      = window_i && !start_i && (st_q != SEQ_DONE);
    assign adv_o      = match && (st_q == SEQ_FIRST);
    assign clear_o    = match && (st_q == SEQ_SECOND);
    assign adv_amt_o  = t1_q;
    assign miss_set_o = (end_i || (start_i && window_i)) &&
                        ((st_q == SEQ_FIRST) || ((st_q == SEQ_SECOND) && !match));

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   st_d = SEQ_IDLE;
            SEQ_FIRST:  if (match) st_d = SEQ_SECOND;
            SEQ_SECOND: if (match) st_d = SEQ_DONE;
            SEQ_DONE:   st_d = SEQ_DONE;
        endcase
        if (end_i) begin
            st_d = SEQ_IDLE;
        end
        if (start_i) begin
            st_d = SEQ_FIRST;
        end
    end

    // state register and delay shadow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
            t1_q <= GAP;
        end else begin
            st_q <= st_d;
            if (start_i) begin
                t1_q <= (t1_i < GAP) ? GAP : t1_i;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            idx_q  <= 1'b0;
        end else begin
            trig_q <= match;
            if (match) begin
                idx_q <= (st_q == SEQ_SECOND);
            end
        end
    end

    assign trig_o = trig_q;
    assign idx_o  = idx_q;
endmodule

// File: rtl/adc_trig_status.sv
module adc_trig_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       idx_i,
    input  logic       busy_i,
    input  logic       miss_set_i,
    input  logic [1:0] clr_i,
    output logic       drop_o,
    output logic       drop_idx_o,
    output logic       miss_o
);
    logic drop_q, drop_idx_q, miss_q;
    logic lost;

    assign lost = trig_i && busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_q     <= 1'b0;
            drop_idx_q <= 1'b0;
            miss_q     <= 1'b0;
        end else begin
            if (lost) begin
                drop_q     <= 1'b1;
                drop_idx_q <= idx_i;
            end else if (clr_i[0]) begin
                drop_q <= 1'b0;
            end
            if (miss_set_i) begin
                miss_q <= 1'b1;
            end else if (clr_i[1]) begin
                miss_q <= 1'b0;
            end
        end
    end

    assign drop_o     = drop_q;
    assign drop_idx_o = drop_idx_q;
    assign miss_o     = miss_q;
endmodule

// File: rtl/adc_dual_trig_seq.sv
module adc_dual_trig_seq #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_sync_i,
    input  logic [CW-1:0] half_period_i,
    input  logic [CW-1:0] delay_t0_i,
    input  logic [CW-1:0] delay_t1_i,
    input  logic          adc_busy_i,
    input  logic [1:0]    flag_clr_i,
    output logic          trig_o,
    output logic          samp_idx_o,
    output logic          window_o,
    output logic          drop_flag_o,
    output logic          drop_idx_o,
    output logic          miss_o
);
    logic          win_start, win_end, win_act;
    logic          hit, run, clr_cnt, adv, miss_set;
    logic [CW-1:0] adv_amt;

    adc_trig_window #(.CW(CW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pwm_sync_i),
        .len_i    (half_period_i),
        .start_o  (win_start),
        .end_o    (win_end),
        .active_o (win_act)
    );

    adc_trig_counter #(.CW(CW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (win_start),
        .t0_i      (delay_t0_i),
        .run_i     (run),
        .clear_i   (clr_cnt),
        .adv_i     (adv),
        .adv_amt_i (adv_amt),
        .hit_o     (hit)
    );

    adc_trig_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (win_start),
        .end_i      (win_end),
        .window_i   (win_act),
        .hit_i      (hit),
        .t1_i       (delay_t1_i),
        .run_o      (run),
        .clear_o    (clr_cnt),
        .adv_o      (adv),
        .adv_amt_o  (adv_amt),
        .trig_o     (trig_o),
        .idx_o      (samp_idx_o),
        .miss_set_o (miss_set)
    );

    adc_trig_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_o),
        .idx_i      (samp_idx_o),
        .busy_i     (adc_busy_i),
        .miss_set_i (miss_set),
        .clr_i      (flag_clr_i),
        .drop_o     (drop_flag_o),
        .drop_idx_o (drop_idx_o),
        .miss_o     (miss_o)
    );

    assign window_o = win_act;
endmodule

// File: rtl/adc_dual_trig_seq_chk.sv
module adc_dual_trig_seq_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwm_sync_i,
    input logic [CW-1:0] half_period_i,
    input logic          adc_busy_i,
    input logic [1:0]    flag_clr_i,
    input logic          trig_o,
    input logic          samp_idx_o,
    input logic          window_o,
    input logic          drop_flag_o,
    input logic          drop_idx_o,
    input logic          miss_o
);
    logic       opening;
    logic [1:0] n_trig_q;

    assign opening = pwm_sync_i && (half_period_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_trig_q <= '0;
        end else if (opening) begin
            n_trig_q <= '0;
        end else if (trig_o && (n_trig_q != 2'd3)) begin
            n_trig_q <= n_trig_q + 2'd1;
        end
    end

    assert_window_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        opening |=> window_o);

    assert_zero_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_sync_i && (half_period_i == '0) && !window_o) |=> !window_o);

    assert_trig_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(window_o));

    assert_no_trig_at_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_o) |-> !trig_o);

    assert_trig_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    assert_two_per_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        n_trig_q <= 2'd2);

    assert_miss_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_o) |-> $past(window_o));

    assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && !flag_clr_i[1]) |=> miss_o);

    assert_drop_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && adc_busy_i) |=> (drop_flag_o && (drop_idx_o == $past(samp_idx_o))));

    assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag_o && !flag_clr_i[0]) |=> drop_flag_o);
endmodule

bind adc_dual_trig_seq adc_dual_trig_seq_chk #(.CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_sync_i    (pwm_sync_i),
    .half_period_i (half_period_i),
    .adc_busy_i    (adc_busy_i),
    .flag_clr_i    (flag_clr_i),
    .trig_o        (trig_o),
    .samp_idx_o    (samp_idx_o),
    .window_o      (window_o),
    .drop_flag_o   (drop_flag_o),
    .drop_idx_o    (drop_idx_o),
    .miss_o        (miss_o)
);

// File: tb/adc_dual_trig_seq_tb_top.sv
module adc_dual_trig_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_sync_i = 1'b0;
    logic [CW-1:0] half_period_i = '0;
    logic [CW-1:0] delay_t0_i = '0;
    logic [CW-1:0] delay_t1_i = '0;
    logic          adc_busy_i = 1'b0;
    logic [1:0]    flag_clr_i = '0;
    logic          trig_o, samp_idx_o, window_o, drop_flag_o, drop_idx_o, miss_o;

    adc_dual_trig_seq #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_sync_i(pwm_sync_i),
        .half_period_i(half_period_i), .delay_t0_i(delay_t0_i),
        .delay_t1_i(delay_t1_i), .adc_busy_i(adc_busy_i),
        .flag_clr_i(flag_clr_i), .trig_o(trig_o), .samp_idx_o(samp_idx_o),
        .window_o(window_o), .drop_flag_o(drop_flag_o),
        .drop_idx_o(drop_idx_o), .miss_o(miss_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        logic        idx;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_fail = 0;
    int   win_hi = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard for trigger pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (window_o) win_hi++;
            if (trig_o) begin
                if (expq.size() == 0) begin
                    check(0, "R4", "unexpected trigger at cycle", cyc, 0);
                end else begin
                    mon_e = expq.pop_front();
                    check(mon_e.at == cyc, mon_e.idx ? "R3" : "R2",
                          "trigger cycle", cyc, mon_e.at);
                    check(samp_idx_o == mon_e.idx, mon_e.idx ? "R3" : "R2",
                          "sample index", samp_idx_o, mon_e.idx);
                end
            end else if (expq.size() > 0 && expq[0].at < cyc) begin
                mon_e = expq.pop_front();
                check(0, mon_e.idx ? "R3" : "R2", "missing trigger due at cycle",
                      cyc, mon_e.at);
            end
        end
    end

    // drive a sync pulse at a negedge; s is the sync edge number
    task automatic send_sync(int h, int t0, int t1, output int unsigned s);
        half_period_i = CW'(h);
        delay_t0_i    = CW'(t0);
        delay_t1_i    = CW'(t1);
        s = cyc + 1;
        pwm_sync_i = 1'b1;
        @(negedge clk);
        pwm_sync_i = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr_i = 2'b11;
        @(negedge clk);
        flag_clr_i = 2'b00;
        @(negedge clk);
        check(miss_o == 1'b0, "R7", "miss after clear", miss_o, 0);
        check(drop_flag_o == 1'b0, "R9", "drop after clear", drop_flag_o, 0);
    endtask

    // busy_sel: 0 none, 1 busy over first trigger, 2 busy over second
    task automatic run_period(int h, int t0, int t1, int busy_sel, bit chg);
        int unsigned s;
        int  t1e;
        bit  second;
        int unsigned ta, tb;
        t1e    = (t1 < 2) ? 2 : t1;
        second = (t0 + t1e <= h - 2);
        ta     = cyc + 1 + 2 + t0;
        tb     = ta + t1e;
        win_hi = 0;
        expq.push_back('{ta, 1'b0});
        if (second) expq.push_back('{tb, 1'b1});
        send_sync(h, t0, t1, s);
        for (int k = 0; k < h + 4; k++) begin
            if (chg && k == 1) begin
                delay_t0_i = CW'(t0 + 7);   // R5: ignored in this window
                delay_t1_i = CW'(t1 + 5);
            end
            adc_busy_i = (busy_sel == 1 && cyc == ta) || (busy_sel == 2 && cyc == tb);
            @(negedge clk);
        end
        adc_busy_i = 1'b0;
        check(win_hi == h, "R1", "window length", win_hi, h);
        check(miss_o == !second, "R6", "miss flag", miss_o, !second);
        check(drop_flag_o == (busy_sel != 0), "R8", "drop flag", drop_flag_o, busy_sel != 0);
        if (busy_sel != 0)
            check(drop_idx_o == (busy_sel == 2), "R8", "dropped index", drop_idx_o, busy_sel == 2);
        check(expq.size() == 0, "R4", "pending expected triggers", expq.size(), 0);
        clear_flags();
    endtask

    initial begin
        int unsigned s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(trig_o == 0, "R10", "trig after reset", trig_o, 0);
        check(samp_idx_o == 0, "R10", "index after reset", samp_idx_o, 0);
        check(window_o == 0, "R10", "window after reset", window_o, 0);
        check(drop_flag_o == 0 && drop_idx_o == 0, "R10", "drop after reset", drop_flag_o, 0);
        check(miss_o == 0, "R10", "miss after reset", miss_o, 0);

        run_period(20, 0, 5, 0, 0);    // R2 immediate first sample
        run_period(20, 3, 15, 0, 0);   // R6 boundary: t0+t1 = H-2
        run_period(20, 3, 16, 0, 0);   // R6 one beyond: second suppressed
        run_period(20, 0, 0, 0, 0);    // R3 spacing clamped to 2
        run_period(24, 2, 6, 0, 1);    // R5 delays changed mid-window
        run_period(20, 1, 5, 2, 0);    // R8 busy over second trigger
        run_period(20, 1, 5, 1, 0);    // R9 busy over first trigger
        run_period(30, 4, 9, 0, 0);    // R4 no extra triggers after second

        // R1 zero half-period is ignored
        win_hi = 0;
        send_sync(0, 0, 3, s1);
        repeat (10) @(negedge clk);
        check(win_hi == 0, "R1", "window cycles for zero length", win_hi, 0);
        check(miss_o == 0, "R1", "miss after zero-length sync", miss_o, 0);

        // R11 restart mid-window after the first trigger
        win_hi = 0;
        expq.push_back('{cyc + 1 + 2, 1'b0});
        send_sync(30, 0, 20, s1);
        repeat (7) @(negedge clk);
        s2 = cyc + 1;
        expq.push_back('{s2 + 2, 1'b0});
        expq.push_back('{s2 + 6, 1'b1});
        send_sync(30, 0, 4, s2);
        repeat (34) @(negedge clk);
        check(miss_o == 1, "R11", "miss after restart", miss_o, 1);
        check(win_hi == 38, "R11", "window cycles across restart", win_hi, 38);
        check(expq.size() == 0, "R11", "pending triggers after restart", expq.size(), 0);
        clear_flags();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule